// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write single 16-bit words in an external asynchronous static RAM that holds 1,048,576 words (20-bit word address). The user side is a request/acknowledge handshake. A request carries a direction, an address, write data and a two-bit lane mask. The controller captures the request and produces the strobe sequence the memory needs. It then returns an acknowledge pulse and, for reads, the returned word.

On the memory side the controller drives the address, a pair of chip selects of opposite polarity, an output enable, a write enable and one enable per byte lane. It also owns one end of a shared tristate data bus. Pulse widths come from the memory access time and the clock period, both given as parameters. The controller rounds the access time up to whole cycles. Between transactions the memory is deselected so it can drop into its low-power state.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is low and after it, until a request arrives: `mem_ce1_n`=1, `mem_ce2`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_lb_n`=1, `mem_ub_n`=1, `ack`=0, `rsp_rdata`=0, and the data bus is not driven.
- R2: The memory is selected (`mem_ce1_n`=0 together with `mem_ce2`=1) in exactly the cycles of an active transaction. In every other cycle, including the acknowledge cycle, it is deselected (`mem_ce1_n`=1, `mem_ce2`=0).
- R3: A write takes WAIT_CYC+2 selected cycles. First comes one setup cycle with `mem_we_n`=1 and address and data already valid. Then `mem_we_n`=0 for WAIT_CYC cycles. Then one hold cycle with `mem_we_n`=1 and the data still driven. The bus carries the write word in all three phases.
- R4: A read takes WAIT_CYC selected cycles with `mem_oe_n`=0 and `mem_we_n`=1. The bus is sampled at the end of the last of these cycles and appears on `rsp_rdata` in the acknowledge cycle. It is held there until the next read completes.
- R5: The controller drives the data bus only during the three write phases. `mem_oe_n` and `mem_we_n` are never low in the same cycle.
- R6: `req_ben` bit 0 selects data bits 7:0 (`mem_lb_n`) and bit 1 selects bits 15:8 (`mem_ub_n`). A lane enable is low only in selected cycles whose mask bit is 1. A write leaves unselected lanes of the memory word unchanged. A read returns zero in the unselected lanes of `rsp_rdata`.
- R7: `ack` is high for exactly one cycle per transaction, the cycle right after the last selected cycle.
- R8: `req_valid` is sampled only while the controller is idle (the acknowledge cycle counts as idle). A request raised during a transaction starts nothing and writes nothing.
- R9: WAIT_CYC equals ACCESS_PS divided by CLK_PERIOD_PS, rounded up, with a minimum of 1. The defaults of 10000 and 6000 give 2.
- R10: `mem_addr` holds the captured request address, unchanged, over every selected cycle of a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write word |
| req_ben | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Last read word, unselected lanes zero |
| mem_addr | output | 20 | Memory address |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low lane enable, active low |
| mem_ub_n | output | 1 | High lane enable, active low |
| mem_dq | inout | 16 | Shared data bus |

## Verification
A request can arrive in the same cycle that the previous transaction is acknowledged. That cycle is idle, so the new request is accepted there. The bench sets up this case by raising `req_valid` at the acknowledge cycle. It then checks that the next transaction's first selected cycle comes right after the acknowledge, with the memory deselected for that one cycle. The opposite collision is a request raised while a write is in its strobe phase. The bench pulses `req_valid` mid-write with a different address and data, then reads that address back and expects its untouched content.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and constant helpers for the asynchronous SRAM controller.
// Assumes: nothing beyond standard SystemVerilog constant functions.
package sram_ctrl_pkg;

    // Sequencer phases; ST_IDLE is the only phase where a request is taken.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD     = 3'd1,
        ST_WSETUP = 3'd2,
        ST_WPULSE = 3'd3,
        ST_WHOLD  = 3'd4
    } ctl_state_t;

    // Whole clock cycles covering the access time, never below one.
    function automatic int unsigned wait_cycles(input int unsigned access_ps,
                                                input int unsigned clk_ps);
        int unsigned n;
        n = (access_ps + clk_ps - 1) / clk_ps;
        return (n == 0) ? 1 : n;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
// Down-counter that measures one strobe window of CYCLES clock cycles.
// Assumes: load is pulsed on the edge that enters a timed phase; expired is
// then high during the last cycle of that phase.
module sram_wait_timer #(
    parameter int unsigned CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CNT_W-1:0] cnt_q;

    // Reload on phase entry, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
// Transaction sequencer: walks read and write phases and raises the ack.
// Assumes: a request is sampled only in ST_IDLE; the timer's expired flag is
// valid during timed phases only.
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       tmr_expired,
    output ctl_state_t state,
    output logic       tmr_load,
    output logic       accept,
    output logic       capture,
    output logic       ack
);
    ctl_state_t state_q, state_d;

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = req_write ? ST_WSETUP : ST_RD;
            ST_RD:     if (tmr_expired) state_d = ST_IDLE;
            ST_WSETUP: state_d = ST_WPULSE;
            ST_WPULSE: if (tmr_expired) state_d = ST_WHOLD;
            ST_WHOLD:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Completion pulse, one cycle after the last selected cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= ((state_q == ST_RD) && tmr_expired) || (state_q == ST_WHOLD);
    end

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign capture  = (state_q == ST_RD) && tmr_expired;
    assign tmr_load = ((state_d == ST_RD) && (state_q != ST_RD)) ||
                      ((state_d == ST_WPULSE) && (state_q != ST_WPULSE));
    assign state    = state_q;

endmodule

// File: rtl/sram_lane_path.sv
// Per-byte-lane data path: holds write bytes and lane mask, captures read bytes.
// Assumes: accept and capture never coincide; unselected lanes read as zero.
module sram_lane_path #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      accept,
    input  logic [LANES*LANE_W-1:0]   req_wdata,
    input  logic [LANES-1:0]          req_ben,
    input  logic                      capture,
    input  logic [LANES*LANE_W-1:0]   dq_in,
    output logic [LANES*LANE_W-1:0]   wdata_q,
    output logic [LANES-1:0]          ben_q,
    output logic [LANES*LANE_W-1:0]   rdata_q
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] wd_r;
        logic [LANE_W-1:0] rd_r;
        logic              be_r;

        // Latch this lane's write byte and enable at request acceptance.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wd_r <= '0;
                be_r <= 1'b0;
            end else if (accept) begin
                wd_r <= req_wdata[g*LANE_W +: LANE_W];
                be_r <= req_ben[g];
            end
        end

        // Capture this lane's read byte, zero when the lane is masked off.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_r <= '0;
            end else if (capture) begin
                rd_r <= be_r ? dq_in[g*LANE_W +: LANE_W] : '0;
            end
        end

        assign wdata_q[g*LANE_W +: LANE_W] = wd_r;
        assign rdata_q[g*LANE_W +: LANE_W] = rd_r;
        assign ben_q[g]                    = be_r;
    end

endmodule

// File: rtl/sram_async_ctrl.sv
// Top level: clocked request port in front of an asynchronous 16-bit SRAM.
// Assumes: the memory's access time is at most ACCESS_PS; board delays are
// covered by that figure; exactly two byte lanes.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 6000,
    parameter int unsigned ACCESS_PS     = 10000,
    parameter int unsigned ADDR_W        = 20,
    parameter int unsigned DATA_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_ben,
    output logic              ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    inout  wire  [DATA_W-1:0] mem_dq
);
    localparam int unsigned LANES    = 2;
    localparam int unsigned LANE_W   = DATA_W / LANES;
    localparam int unsigned WAIT_CYC = wait_cycles(ACCESS_PS, CLK_PERIOD_PS);

    ctl_state_t        state;
    logic              tmr_load, tmr_expired, accept, capture;
    logic              sel, drive;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  ben_q;
    logic [LANES-1:0]  lane_n;

    sram_wait_timer #(.CYCLES(WAIT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    sram_ctrl_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .tmr_expired (tmr_expired),
        .state       (state),
        .tmr_load    (tmr_load),
        .accept      (accept),
        .capture     (capture),
        .ack         (ack)
    );

    sram_lane_path #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_wdata (req_wdata),
        .req_ben   (req_ben),
        .capture   (capture),
        .dq_in     (mem_dq),
        .wdata_q   (wdata_q),
        .ben_q     (ben_q),
        .rdata_q   (rsp_rdata)
    );

    // Address register, loaded once per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (accept) addr_q <= req_addr;
    end

    assign sel       = (state != ST_IDLE);
    assign drive     = (state == ST_WSETUP) || (state == ST_WPULSE) || (state == ST_WHOLD);
    assign mem_ce1_n = ~sel;
    assign mem_ce2   = sel;
    assign mem_oe_n  = ~(state == ST_RD);
    assign mem_we_n  = ~(state == ST_WPULSE);
    assign lane_n    = ~({LANES{sel}} & ben_q);
    assign mem_lb_n  = lane_n[0];
    assign mem_ub_n  = lane_n[LANES-1];
    assign mem_addr  = addr_q;
    assign mem_dq    = drive ? wdata_q : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_ctrl_chk.sv
// Protocol checker for sram_async_ctrl, watching its ports only.
// Assumes: bound to every instance of the top module.
module sram_ctrl_chk #(
    parameter int unsigned ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce1_n,
    input logic              mem_ce2,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n
);
    // Deselected in the acknowledge cycle.
    p_deselect_on_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (mem_ce1_n && !mem_ce2));

    // Write enable falls only after a selected cycle with a settled address.
    p_we_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(mem_ce2) && $stable(mem_addr)));

    // Write enable rises while still selected, address unchanged.
    p_we_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_ce2 && !mem_ce1_n && $stable(mem_addr)));

    // Output enable and write enable never low together.
    p_oe_we_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    // Lane enables only while selected.
    p_lane_needs_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_lb_n || !mem_ub_n) |-> mem_ce2);

    // Acknowledge is a single-cycle pulse.
    p_ack_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // Address steady across consecutive selected cycles.
    p_addr_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ce2 && $past(mem_ce2)) |-> $stable(mem_addr));

endmodule

bind sram_async_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .mem_addr  (mem_addr),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_lb_n  (mem_lb_n),
    .mem_ub_n  (mem_ub_n)
);

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TB_WAIT    = 2;     // ceil(10000/6000)
    localparam int WDOG_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_ben = '0;
    logic        ack;
    logic [15:0] rsp_rdata;
    logic [19:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
    wire  [15:0] mem_dq;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_async_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ben(req_ben),
        .ack(ack), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq(mem_dq)
    );

    // ---------------- memory model driven by the pins ----------------
    logic [15:0] mem_arr [256];
    logic [15:0] gold    [256];
    function automatic logic [15:0] dflt(input int i);
        return 16'h5A00 ^ {i[7:0], i[7:0]};
    endfunction
    initial for (int i = 0; i < 256; i++) begin mem_arr[i] = dflt(i); gold[i] = dflt(i); end

    wire        m_sel  = !mem_ce1_n && mem_ce2;
    wire        m_rd   = m_sel && !mem_oe_n && mem_we_n;
    wire [15:0] m_word = mem_arr[mem_addr[7:0]];
    assign mem_dq[7:0]  = (m_rd && !mem_lb_n) ? m_word[7:0]  : 8'hzz;
    assign mem_dq[15:8] = (m_rd && !mem_ub_n) ? m_word[15:8] : 8'hzz;

    always @(posedge clk) begin
        if (m_sel && !mem_we_n) begin
            if (!mem_lb_n) mem_arr[mem_addr[7:0]][7:0]  <= mem_dq[7:0];
            if (!mem_ub_n) mem_arr[mem_addr[7:0]][15:8] <= mem_dq[15:8];
        end
    end

    // ---------------- cycle reference model ----------------
    int          m_phase = 0;
    bit          m_wr = 0, m_ack = 0;
    logic [19:0] m_addr = '0;
    logic [15:0] m_wd = '0, m_rdata = '0;
    logic [1:0]  m_be = '0;
    int          accepted = 0, acks_seen = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_ack = 0; m_rdata = '0; m_addr = '0; m_be = '0; m_wr = 0;
        end else begin
            m_ack = 0;
            if (m_phase == 0) begin
                if (req_valid) begin
                    m_wr = req_write; m_addr = req_addr; m_wd = req_wdata; m_be = req_ben;
                    m_phase = 1; accepted++;
                    if (req_write) begin
                        if (req_ben[0]) gold[req_addr[7:0]][7:0]  = req_wdata[7:0];
                        if (req_ben[1]) gold[req_addr[7:0]][15:8] = req_wdata[15:8];
                    end
                end
            end else if (m_phase == (m_wr ? TB_WAIT + 2 : TB_WAIT)) begin
                if (!m_wr)
                    m_rdata = {m_be[1] ? gold[m_addr[7:0]][15:8] : 8'h00,
                               m_be[0] ? gold[m_addr[7:0]][7:0]  : 8'h00};
                m_phase = 0; m_ack = 1;
            end else begin
                m_phase++;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- per-cycle comparison away from the edge ----------------
    int oe_run = 0;
    always @(negedge clk) begin
        if (cmp_en) begin
            bit sel_e;
            sel_e = (m_phase != 0);
            check("R2", "ce1_n", mem_ce1_n, !sel_e);
            check("R2", "ce2", mem_ce2, sel_e);
            check("R4", "oe_n", mem_oe_n, !(sel_e && !m_wr));
            check("R3", "we_n", mem_we_n, !(sel_e && m_wr && m_phase >= 2 && m_phase <= TB_WAIT + 1));
            check("R6", "lb_n", mem_lb_n, !(sel_e && m_be[0]));
            check("R6", "ub_n", mem_ub_n, !(sel_e && m_be[1]));
            check("R7", "ack", ack, m_ack);
            check("R4", "rsp_rdata", rsp_rdata, m_rdata);
            check("R5", "oe_we_not_both_low", (!mem_oe_n && !mem_we_n), 1'b0);
            if (sel_e) check("R10", "mem_addr", mem_addr, m_addr);
            if (sel_e && m_wr) check("R3", "write bus", mem_dq, m_wd);
            if (ack) acks_seen++;
            if (!mem_oe_n) oe_run++;
            else begin
                if (oe_run != 0) check("R9", "oe low run", oe_run, TB_WAIT);
                oe_run = 0;
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit wr, input logic [19:0] a, input logic [15:0] d,
                         input logic [1:0] be, input bit now);
        if (!now) @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = d; req_ben = be; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!ack) @(negedge clk);
    endtask

    task automatic read_expect(input string req, input logic [19:0] a,
                               input logic [1:0] be, input logic [15:0] exp);
        issue(1'b0, a, 16'h0, be, 1'b0);
        check(req, "read word", rsp_rdata, exp);
    endtask

    int wdog = 0;
    always @(posedge clk) begin
        wdog++;
        if (wdog > WDOG_LIMIT) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", wdog, WDOG_LIMIT);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        cmp_en = 1'b1;
        // R1: reset state at the pins
        check("R1", "reset ce1_n", mem_ce1_n, 1'b1);
        check("R1", "reset ce2", mem_ce2, 1'b0);
        check("R1", "reset oe/we", {mem_oe_n, mem_we_n}, 2'b11);
        check("R1", "reset lanes", {mem_lb_n, mem_ub_n}, 2'b11);
        check("R1", "reset ack/rdata", {ack, rsp_rdata}, 17'h0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "idle after reset ce1_n", mem_ce1_n, 1'b1);

        // full-word write and read back
        issue(1'b1, 20'hA3C11, 16'hBEEF, 2'b11, 1'b0);
        read_expect("R3", 20'hA3C11, 2'b11, 16'hBEEF);
        // low lane only write: high byte keeps old content (R6)
        issue(1'b1, 20'h00022, 16'h1234, 2'b01, 1'b0);
        read_expect("R6", 20'h00022, 2'b11, {dflt(8'h22) >> 8, 8'h34});
        // high lane only write, then read only the low lane: high returns zero (R6)
        issue(1'b1, 20'h7F033, 16'hC3D4, 2'b10, 1'b0);
        read_expect("R6", 20'h7F033, 2'b01, {8'h00, dflt(8'h33) & 16'h00FF} & 16'h00FF);
        read_expect("R6", 20'h7F033, 2'b10, 16'hC300);
        // empty mask write changes nothing (R6)
        issue(1'b1, 20'h12344, 16'hFFFF, 2'b00, 1'b0);
        read_expect("R6", 20'h12344, 2'b11, dflt(8'h44));
        // boundary addresses
        issue(1'b1, 20'h00000, 16'h0F0F, 2'b11, 1'b0);
        issue(1'b1, 20'hFFFFF, 16'hF0F0, 2'b11, 1'b0);
        read_expect("R10", 20'h00000, 2'b11, 16'h0F0F);
        read_expect("R10", 20'hFFFFF, 2'b11, 16'hF0F0);
        // back-to-back: new request raised in the acknowledge cycle (R8)
        issue(1'b1, 20'h40055, 16'h5566, 2'b11, 1'b0);
        issue(1'b1, 20'h40066, 16'h6677, 2'b11, 1'b1);
        issue(1'b0, 20'h40055, 16'h0, 2'b11, 1'b1);
        check("R8", "back-to-back read", rsp_rdata, 16'h5566);
        read_expect("R8", 20'h40066, 2'b11, 16'h6677);
        // request raised mid-write is ignored (R8)
        @(negedge clk);
        req_write = 1'b1; req_addr = 20'h90077; req_wdata = 16'hABCD; req_ben = 2'b11;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        req_addr = 20'h90088; req_wdata = 16'hDEAD; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!ack) @(negedge clk);
        read_expect("R8", 20'h90088, 2'b11, dflt(8'h88));
        read_expect("R8", 20'h90077, 2'b11, 16'hABCD);
        // every accepted request acknowledged once (R7)
        repeat (3) @(negedge clk);
        check("R7", "ack count", acks_seen, accepted);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule